// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block sits between the output-control register of a six-channel half-bridge driver and the gate drivers. It receives the already-digitized comparator flags for supply undervoltage, supply overvoltage, junction-temperature warning and thermal shutdown. It combines them with the per-bridge high-side and low-side enable bits to produce the final gate enables and a high-impedance indication for every bridge. The active-low reset input represents the logic-supply power-on reset: while it is low the whole block is cleared and every bridge floats.

Each fault class has its own recovery policy. Supply faults remove the gate drive only while the condition lasts, and the bridges return on their own afterwards. Thermal shutdown holds the gates off until software clears its status bit and the over-temperature is gone. A logic-supply reset is reported afterwards by an active-low power-on flag, which software acknowledges with a strobe. Every status bit is sticky. A one-cycle clear strobe resets it, and a fault that is still present sets it again in the same cycle. The control inputs are never modified, so the previous output pattern reappears when a supply fault ends. All interfaces are plain level or strobe pins; no data stream passes through the block, so it has no valid/ready handshake.

Top module: `fault_supervisor`

## Requirements
- R1: Each comparator flag passes a two-flop synchronizer. A flag driven before clock edge k reaches the gate outputs just after edge k+1 and the status bits just after edge k+2.
- R2: While the synchronized supply-undervoltage flag is high, all `hs_gate` and `ls_gate` bits are 0. `stat_uv` is then set and stays 1 after the flag drops, until it is cleared.
- R3: When the synchronized undervoltage or overvoltage flag returns low, the gates follow the control bits again with no software action, even while `stat_uv` or `stat_ov` still reads 1.
- R4: While the synchronized supply-overvoltage flag is high, all gates are 0. `stat_ov` is set and latched.
- R5: A synchronized thermal-shutdown flag sets `stat_tsd`. While `stat_tsd` is 1, all gates stay 0 whatever the control bits are.
- R6: A `clr_tsd` strobe leaves `stat_tsd` at 0 only if the thermal-shutdown flag has ended. Otherwise the bit reads 1 again.
- R7: A synchronized warning flag sets `stat_tpw`, which stays latched. A `clr_tpw` strobe leaves it at 0 only if the warning flag is low.
- R8: When a synchronized flag is high in the same cycle as its clear strobe, the status bit is 1 after that edge (set wins).
- R9: While `rst_n` is low, all gates are 0, every `hb_hiz` bit is 1, and all status bits, including `stat_npor`, are 0.
- R10: `stat_npor` becomes 1 only at the edge after a `npor_ack` strobe. It then stays 1 until the next reset.
- R11: Bit i of each control and gate vector belongs to bridge i. When both control bits of a bridge are 1, both of its gates are 0. `hs_gate[i]` and `ls_gate[i]` are never both 1.
- R12: `hb_hiz[i]` is 1 exactly when neither gate of bridge i is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Logic-supply power-on reset, active low, asynchronous |
| tw_flag | input | 1 | Temperature warning comparator flag (asynchronous) |
| tsd_flag | input | 1 | Thermal shutdown comparator flag (asynchronous) |
| vs_uv_flag | input | 1 | Power-supply undervoltage comparator flag (asynchronous) |
| vs_ov_flag | input | 1 | Power-supply overvoltage comparator flag (asynchronous) |
| hs_en_ctrl | input | NUM_HB | High-side enable request per bridge |
| ls_en_ctrl | input | NUM_HB | Low-side enable request per bridge |
| clr_tpw | input | 1 | Clear strobe for stat_tpw |
| clr_tsd | input | 1 | Clear strobe for stat_tsd |
| clr_uv | input | 1 | Clear strobe for stat_uv |
| clr_ov | input | 1 | Clear strobe for stat_ov |
| npor_ack | input | 1 | Strobe that sets stat_npor to 1 |
| hs_gate | output | NUM_HB | Final high-side gate enable per bridge |
| ls_gate | output | NUM_HB | Final low-side gate enable per bridge |
| hb_hiz | output | NUM_HB | Bridge is floating (both gates off) |
| stat_tpw | output | 1 | Latched temperature warning |
| stat_tsd | output | 1 | Latched thermal shutdown |
| stat_uv | output | 1 | Latched supply undervoltage |
| stat_ov | output | 1 | Latched supply overvoltage |
| stat_npor | output | 1 | Power-on flag, 0 after a reset until acknowledged |

## Verification
The bench targets the cycle in which gates drop and return around a supply fault. A design that latches supply faults would never restore the outputs, and one that ignores the synchronizer would switch a cycle early. It clears thermal shutdown and warning status while the condition is still present and again after it has ended. A design that lets the clear win, or releases the gates before the clear, would show a gate or status bit at the wrong level. It also drives both control bits of a bridge at once, pulses reset in the middle of a run with faults latched, and checks that the power-on flag returns to 0 and ignores everything except its acknowledge strobe.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int FLT_W = 4;

  // Position of each fault inside the internal flag vectors
  typedef enum int unsigned {
    IDX_TPW = 0,
    IDX_TSD = 1,
    IDX_UV  = 2,
    IDX_OV  = 3
  } flt_idx_e;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fsup_sticky.sv
module fsup_sticky #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  // Set has priority over clear in the same cycle
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[b] <= 1'b0;
      else if (set[b]) q[b] <= 1'b1;
      else if (clr[b]) q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsup_hb_gate.sv
module fsup_hb_gate #(
  parameter int NUM_HB = 6
) (
  input  logic              kill,
  input  logic [NUM_HB-1:0] hs_req,
  input  logic [NUM_HB-1:0] ls_req,
  output logic [NUM_HB-1:0] hs_gate,
  output logic [NUM_HB-1:0] ls_gate,
  output logic [NUM_HB-1:0] hiz
);
  for (genvar g = 0; g < NUM_HB; g++) begin : g_bridge
    logic conflict;
    assign conflict   = hs_req[g] & ls_req[g];
    assign hs_gate[g] = hs_req[g] & ~conflict & ~kill;
    assign ls_gate[g] = ls_req[g] & ~conflict & ~kill;
    assign hiz[g]     = ~(hs_gate[g] | ls_gate[g]);
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NUM_HB      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_flag,
  input  logic              tsd_flag,
  input  logic              vs_uv_flag,
  input  logic              vs_ov_flag,
  input  logic [NUM_HB-1:0] hs_en_ctrl,
  input  logic [NUM_HB-1:0] ls_en_ctrl,
  input  logic              clr_tpw,
  input  logic              clr_tsd,
  input  logic              clr_uv,
  input  logic              clr_ov,
  input  logic              npor_ack,
  output logic [NUM_HB-1:0] hs_gate,
  output logic [NUM_HB-1:0] ls_gate,
  output logic [NUM_HB-1:0] hb_hiz,
  output logic              stat_tpw,
  output logic              stat_tsd,
  output logic              stat_uv,
  output logic              stat_ov,
  output logic              stat_npor
);
  import fsup_pkg::*;

  logic [FLT_W-1:0] flt_raw;
  logic [FLT_W-1:0] flt_sync;
  logic [FLT_W-1:0] flt_clr;
  logic [FLT_W-1:0] flt_stat;
  logic             kill;
  logic             npor_q;

  assign flt_raw[IDX_TPW] = tw_flag;
  assign flt_raw[IDX_TSD] = tsd_flag;
  assign flt_raw[IDX_UV]  = vs_uv_flag;
  assign flt_raw[IDX_OV]  = vs_ov_flag;

  assign flt_clr[IDX_TPW] = clr_tpw;
  assign flt_clr[IDX_TSD] = clr_tsd;
  assign flt_clr[IDX_UV]  = clr_uv;
  assign flt_clr[IDX_OV]  = clr_ov;

  fsup_sync #(.WIDTH(FLT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(flt_raw), .q(flt_sync)
  );

  fsup_sticky #(.WIDTH(FLT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set(flt_sync), .clr(flt_clr), .q(flt_stat)
  );

  // Power-on flag: forced low only by reset, raised by acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        npor_q <= 1'b0;
    else if (npor_ack) npor_q <= 1'b1;
  end

  // Supply faults act only while present; thermal shutdown also via latch
  assign kill = ~rst_n
              | flt_sync[IDX_UV]
              | flt_sync[IDX_OV]
              | flt_sync[IDX_TSD]
              | flt_stat[IDX_TSD];

  fsup_hb_gate #(.NUM_HB(NUM_HB)) u_gate (
    .kill(kill), .hs_req(hs_en_ctrl), .ls_req(ls_en_ctrl),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .hiz(hb_hiz)
  );

  assign stat_tpw  = flt_stat[IDX_TPW];
  assign stat_tsd  = flt_stat[IDX_TSD];
  assign stat_uv   = flt_stat[IDX_UV];
  assign stat_ov   = flt_stat[IDX_OV];
  assign stat_npor = npor_q;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int NUM_HB = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        flt_sync,
  input logic [NUM_HB-1:0] hs_gate,
  input logic [NUM_HB-1:0] ls_gate,
  input logic [NUM_HB-1:0] hb_hiz,
  input logic              stat_tpw,
  input logic              stat_tsd,
  input logic              stat_uv,
  input logic              stat_ov,
  input logic              stat_npor,
  input logic              clr_uv,
  input logic              npor_ack
);
  import fsup_pkg::*;

  assert_no_shoot_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate & ls_gate) == '0);

  assert_uv_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_sync[IDX_UV] |-> (hs_gate == '0 && ls_gate == '0));

  assert_uv_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_uv && !clr_uv) |=> stat_uv);

  assert_ov_gates_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_sync[IDX_OV] |-> (hs_gate == '0 && ls_gate == '0));

  assert_tsd_holds_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_tsd |-> (hs_gate == '0 && ls_gate == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_sync[IDX_TPW] |=> stat_tpw);

  assert_npor_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_npor |=> stat_npor);

  assert_npor_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_npor && !npor_ack) |=> !stat_npor);

  // R9: reset state sampled between edges
  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      assert_reset_state_R9: assert (hs_gate == '0 && ls_gate == '0 && hb_hiz == '1
        && !stat_tpw && !stat_tsd && !stat_uv && !stat_ov && !stat_npor);
    end
  end
endmodule

bind fault_supervisor fsup_checker #(.NUM_HB(NUM_HB)) i_fsup_checker (
  .clk(clk), .rst_n(rst_n), .flt_sync(flt_sync),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .hb_hiz(hb_hiz),
  .stat_tpw(stat_tpw), .stat_tsd(stat_tsd), .stat_uv(stat_uv),
  .stat_ov(stat_ov), .stat_npor(stat_npor),
  .clr_uv(clr_uv), .npor_ack(npor_ack)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int CLK_P  = 10;
  localparam int NUM_HB = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic tw_flag, tsd_flag, vs_uv_flag, vs_ov_flag;
  logic [NUM_HB-1:0] hs_en_ctrl, ls_en_ctrl;
  logic clr_tpw, clr_tsd, clr_uv, clr_ov, npor_ack;
  logic [NUM_HB-1:0] hs_gate, ls_gate, hb_hiz;
  logic stat_tpw, stat_tsd, stat_uv, stat_ov, stat_npor;

  always #(CLK_P/2) clk = ~clk;

  fault_supervisor #(.NUM_HB(NUM_HB), .SYNC_STAGES(2)) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n),
    .tw_flag(tw_flag), .tsd_flag(tsd_flag), .vs_uv_flag(vs_uv_flag), .vs_ov_flag(vs_ov_flag),
    .hs_en_ctrl(hs_en_ctrl), .ls_en_ctrl(ls_en_ctrl),
    .clr_tpw(clr_tpw), .clr_tsd(clr_tsd), .clr_uv(clr_uv), .clr_ov(clr_ov),
    .npor_ack(npor_ack),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .hb_hiz(hb_hiz),
    .stat_tpw(stat_tpw), .stat_tsd(stat_tsd), .stat_uv(stat_uv),
    .stat_ov(stat_ov), .stat_npor(stat_npor)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R9";

  // Reference model state: bit 0 warning, 1 shutdown, 2 undervoltage, 3 overvoltage
  logic [3:0] m_s1, m_s2, m_st;
  logic       m_npor;
  logic [3:0] flag_q[$];

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_st = '0; m_npor = 1'b0;
      flag_q.delete();
    end else begin
      m_st   = m_s2 | (m_st & ~{clr_ov, clr_uv, clr_tsd, clr_tpw});
      m_npor = m_npor | npor_ack;
      flag_q.push_back({vs_ov_flag, vs_uv_flag, tsd_flag, tw_flag});
      m_s2   = m_s1;
      m_s1   = flag_q[$];
    end
  endtask

  task automatic compare();
    logic kill;
    logic [NUM_HB-1:0] eh, el;
    kill = !rst_n || m_s2[1] || m_s2[2] || m_s2[3] || m_st[1];
    for (int i = 0; i < NUM_HB; i++) begin
      eh[i] = hs_en_ctrl[i] && !ls_en_ctrl[i] && !kill;
      el[i] = ls_en_ctrl[i] && !hs_en_ctrl[i] && !kill;
    end
    chk(tag, {hs_gate, ls_gate, hb_hiz, stat_ov, stat_uv, stat_tsd, stat_tpw, stat_npor},
             {eh, el, ~(eh | el), m_st, m_npor});
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      #(CLK_P/4);
      compare();
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    {tw_flag, tsd_flag, vs_uv_flag, vs_ov_flag} = '0;
    {clr_tpw, clr_tsd, clr_uv, clr_ov, npor_ack} = '0;
    hs_en_ctrl = '0; ls_en_ctrl = '0;
    m_s1 = '0; m_s2 = '0; m_st = '0; m_npor = 1'b0;

    // R9: reset state with requests present
    tag = "R9";
    hs_en_ctrl = 6'b110011; ls_en_ctrl = 6'b001100;
    tick(3);
    chk("R9", {hb_hiz, stat_npor, stat_tpw}, {6'b111111, 1'b0, 1'b0});
    rst_n = 1'b1;

    // R11 / R12: overlapping requests on bridges 1 and 3
    tag = "R11";
    hs_en_ctrl = 6'b101011; ls_en_ctrl = 6'b011010;
    tick(2);
    chk("R11", {hs_gate, ls_gate}, {6'b100001, 6'b010000});
    tag = "R12";
    chk("R12", hb_hiz, 6'b001110);

    // R10: power-on flag
    tag = "R10";
    clr_tpw = 1'b1; clr_uv = 1'b1; tick(1); clr_tpw = 1'b0; clr_uv = 1'b0;
    chk("R10", stat_npor, 1'b0);
    npor_ack = 1'b1; tick(1); npor_ack = 1'b0;
    chk("R10", stat_npor, 1'b1);
    tick(2);

    // R1 / R2: undervoltage reaches the gates after two edges
    hs_en_ctrl = 6'b000111; ls_en_ctrl = 6'b111000;
    tick(1);
    tag = "R1";
    vs_uv_flag = 1'b1;
    tick(1);
    chk("R1", hs_gate, 6'b000111);
    tick(1);
    chk("R1", {hs_gate, ls_gate}, 12'h000);
    chk("R1", stat_uv, 1'b0);
    tag = "R2";
    tick(3);
    chk("R2", stat_uv, 1'b1);
    vs_uv_flag = 1'b0;
    tag = "R3";
    tick(3);
    chk("R3", {hs_gate, ls_gate, stat_uv}, {6'b000111, 6'b111000, 1'b1});
    clr_uv = 1'b1; tick(1); clr_uv = 1'b0;
    chk("R2", stat_uv, 1'b0);

    // R4: overvoltage
    tag = "R4";
    vs_ov_flag = 1'b1;
    tick(4);
    chk("R4", {hs_gate, ls_gate, stat_ov}, {12'h000, 1'b1});
    vs_ov_flag = 1'b0;
    tag = "R3";
    tick(3);
    chk("R3", {hs_gate, stat_ov}, {6'b000111, 1'b1});
    clr_ov = 1'b1; tick(1); clr_ov = 1'b0;

    // R5 / R6: thermal shutdown
    tag = "R5";
    tsd_flag = 1'b1;
    tick(4);
    chk("R5", {hs_gate, ls_gate, stat_tsd}, {12'h000, 1'b1});
    tag = "R6";
    clr_tsd = 1'b1; tick(1); clr_tsd = 1'b0;
    chk("R6", stat_tsd, 1'b1);
    tsd_flag = 1'b0;
    tag = "R5";
    tick(4);
    chk("R5", {hs_gate, ls_gate, stat_tsd}, {12'h000, 1'b1});
    tag = "R6";
    clr_tsd = 1'b1; tick(1); clr_tsd = 1'b0;
    chk("R6", {stat_tsd, hs_gate}, {1'b0, 6'b000111});

    // R7: warning
    tag = "R7";
    tw_flag = 1'b1;
    tick(3);
    chk("R7", {stat_tpw, hs_gate}, {1'b1, 6'b000111});
    clr_tpw = 1'b1; tick(1); clr_tpw = 1'b0;
    chk("R7", stat_tpw, 1'b1);
    tw_flag = 1'b0;
    tick(3);
    chk("R7", stat_tpw, 1'b1);
    clr_tpw = 1'b1; tick(1); clr_tpw = 1'b0;
    chk("R7", stat_tpw, 1'b0);

    // R8: set against a held clear
    tag = "R8";
    tw_flag = 1'b1; vs_uv_flag = 1'b1;
    tick(2);
    clr_tpw = 1'b1; clr_uv = 1'b1;
    tick(2);
    chk("R8", {stat_tpw, stat_uv}, 2'b11);
    clr_tpw = 1'b0; clr_uv = 1'b0;
    tw_flag = 1'b0; vs_uv_flag = 1'b0;
    tick(3);

    // R11 sweep of control patterns
    tag = "R11";
    for (int i = 0; i < 24; i++) begin
      hs_en_ctrl = 6'(i * 13 + 5);
      ls_en_ctrl = 6'(i * 29 + 3);
      tick(1);
    end

    // R9: reset in the middle of a run with faults latched
    tag = "R9";
    vs_ov_flag = 1'b1;
    tick(4);
    #1 rst_n = 1'b0;
    #1 chk("R9", {hs_gate, ls_gate, hb_hiz, stat_ov, stat_npor}, {12'h000, 6'b111111, 2'b00});
    vs_ov_flag = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tag = "R10";
    tick(2);
    chk("R10", stat_npor, 1'b0);

    finish_run();
  end
endmodule